// File: doc/BRIEF.md
# Chained-Retrigger Watchdog Counter Bank

This block holds four 64-bit down-counters behind a small register port. Any of them can be chosen to raise the watchdog reset request. A counter can run on its own as a one-shot timer. It can also be armed in hardware-signal mode, where it reloads and restarts whenever the end-count pulse of the counter just below it fires. Software uses this to keep the watchdog alive without ever stopping it. A helper counter is loaded with zero. Each keep-alive is a disable write and an enable write to that helper. The helper's immediate end-count then reloads the watchdog counter, so the watchdog keeps counting the whole time.

Each counter decrements once per prescale period. Its live count is read as two 32-bit words. Reading the low word captures the high word at the same moment, so a later read of the high word gives a coherent 64-bit value. The register port is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is sampled high. Read data appears on `rdata` in the cycle after the edge that samples `rd_en`, and it holds there until the next read. A watchdog expiry raises `wdog_rst_req` for one clock.

Top module: `chain_wdog_bank`

## Requirements
- R1: After reset every control word, every count word and the select register read 0, and `wdog_rst_req` is low.
- R2: The control word of counter i is at byte address i*0x10, its count low word at i*0x10+4 and its count high word at i*0x10+8. The select register is at 0x40. Read data is valid in the cycle after `rd_en` is sampled, and any other address reads 0.
- R3: The control word has these fields: bit 0 enable, bit 1 active, bits [3:2] mode, bits [7:4] trigger source, bits [15:8] prescale. Bit 1 is read-only and writes to it are ignored. Bits [31:16] always read 0.
- R4: A counter with mode other than 2'b11 starts when a write changes its enable from 0 to 1. On that edge it loads its reload value and becomes active. It then decrements once every P clocks, where P is the prescale value and any value below 2 counts as 2. When its count is 0 while active, it gives an end-count pulse for exactly one clock and its active flag clears. A reload value of 0 gives the pulse in the cycle right after the enabling write.
- R5: A counter with mode 2'b11 does not start when it is enabled. While it is enabled and its trigger source is 4'h5, an end-count pulse from counter i-1 reloads it and makes it active. Counter 0 has no such neighbour, and other source codes never trigger.
- R6: Writing enable 0 clears the active flag at that edge and freezes the count.
- R7: Writes to the count words set only the reload value. The count that is read back is the live count, and the writes do not change it.
- R8: Reading a count low word captures that counter's live high word. A read of its high word returns the captured value, which is 0 before any capture.
- R9: Bits [3:0] of the select register choose the watchdog counters, one bit per counter, and 0 selects none. `wdog_rst_req` is high for one clock, in the cycle after a selected counter's end-count pulse.
- R10: A keep-alive restarts the watchdog counter from its reload value. The keep-alive is a disable write followed by an enable write to a zero-loaded one-shot counter below a mode-2'b11 source-5 watchdog counter. Regular keep-alives therefore stop `wdog_rst_req` from rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read strobe |
| wdog_rst_req | output | 1 | One-clock watchdog reset request |

## Verification
The assertions check on every cycle that:
- no counter's end-count pulse lasts more than one clock;
- an active counter is always enabled;
- an idle counter's count changes only when the counter starts;
- the reset request follows a selected end-count pulse exactly one cycle later and never rises otherwise.

The decode of the register map, the coherent two-word read, the prescaled expiry time, the neighbour retrigger and a keep-alive sequence holding off the reset request can only be shown by the bench's directed and random scenarios.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int unsigned PRE_W = 8;
  localparam int unsigned SRC_W = 4;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_LO   = 4'h4;
  localparam logic [3:0] OFS_HI   = 4'h8;

  localparam logic [1:0]       MODE_HWSIG = 2'b11;
  localparam logic [SRC_W-1:0] SRC_PREV   = 4'h5;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SRC_W-1:0] src;
    logic [1:0]       mode;
    logic             en;
  } cnt_cfg_t;
endpackage

// File: rtl/cwb_tick.sv
module cwb_tick #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  localparam logic [PRE_W-1:0] MIN_DIV = PRE_W'(2);

  logic [PRE_W-1:0] pc_q;
  logic [PRE_W-1:0] div_eff;

  assign div_eff = (div < MIN_DIV) ? MIN_DIV : div;
  assign tick    = run && (pc_q == div_eff - PRE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (clear) begin
      pc_q <= '0;
    end else if (run) begin
      pc_q <= tick ? '0 : pc_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/cwb_counter.sv
module cwb_counter
  import cwb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                trig_in,
  output cnt_cfg_t            cfg_o,
  output logic                active_o,
  output logic [2*DATA_W-1:0] count_o,
  output logic                endc_o
);
  localparam int unsigned CW = 2 * DATA_W;

  cnt_cfg_t        cfg_q;
  cnt_cfg_t        cfg_d;
  logic [CW-1:0]   reload_q;
  logic [CW-1:0]   count_q;
  logic            active_q;
  logic            endc;
  logic            trig_hit;
  logic            sw_start;
  logic            sw_stop;
  logic            restart;
  logic            tick;

  assign cfg_d.en   = wdata[0];
  assign cfg_d.mode = wdata[3:2];
  assign cfg_d.src  = wdata[4 +: SRC_W];
  assign cfg_d.pre  = wdata[8 +: PRE_W];

  assign endc     = active_q && (count_q == '0);
  assign trig_hit = cfg_q.en && (cfg_q.mode == MODE_HWSIG) &&
                    (cfg_q.src == SRC_PREV) && trig_in;
  assign sw_start = ctrl_we && cfg_d.en && !cfg_q.en && (cfg_d.mode != MODE_HWSIG);
  assign sw_stop  = ctrl_we && !cfg_d.en;
  assign restart  = !sw_stop && (sw_start || trig_hit);

  cwb_tick #(.PRE_W(PRE_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart || sw_stop),
    .run   (active_q && !endc),
    .div   (cfg_q.pre),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_we) cfg_q <= cfg_d;
      if (lo_we)   reload_q[DATA_W-1:0]  <= wdata;
      if (hi_we)   reload_q[CW-1:DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (sw_stop) begin
      active_q <= 1'b0;
    end else if (restart) begin
      active_q <= 1'b1;
      count_q  <= reload_q;
    end else if (endc) begin
      active_q <= 1'b0;
    end else if (active_q && tick) begin
      count_q <= count_q - CW'(1);
    end
  end

  assign cfg_o    = cfg_q;
  assign active_o = active_q;
  assign count_o  = count_q;
  assign endc_o   = endc;
endmodule

// File: rtl/cwb_regif.sv
module cwb_regif
  import cwb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [NUM_CNT-1:0]                  wsel,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]      ctrl_rd,
  input  logic [NUM_CNT-1:0][2*DATA_W-1:0]    count_rd,
  output logic [NUM_CNT-1:0]                  ctrl_we,
  output logic [NUM_CNT-1:0]                  lo_we,
  output logic [NUM_CNT-1:0]                  hi_we,
  output logic [NUM_CNT-1:0]                  sel,
  output logic [DATA_W-1:0]                   rdata
);
  localparam int unsigned IDX_W    = ADDR_W - 4;
  localparam int unsigned CW       = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CNT * 16);

  logic [IDX_W-1:0]              idx;
  logic [3:0]                    ofs;
  logic                          in_bank;
  logic [NUM_CNT-1:0]            hit;
  logic [NUM_CNT-1:0][DATA_W-1:0] hold_q;
  logic [NUM_CNT-1:0]            sel_q;
  logic [DATA_W-1:0]             rd_mux;
  logic [DATA_W-1:0]             rdata_q;

  assign idx     = addr[ADDR_W-1:4];
  assign ofs     = addr[3:0];
  assign in_bank = addr < SEL_ADDR;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    assign hit[i]     = in_bank && (idx == IDX_W'(i));
    assign ctrl_we[i] = wr_en && hit[i] && (ofs == OFS_CTRL);
    assign lo_we[i]   = wr_en && hit[i] && (ofs == OFS_LO);
    assign hi_we[i]   = wr_en && hit[i] && (ofs == OFS_HI);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[i] <= '0;
      end else if (rd_en && hit[i] && (ofs == OFS_LO)) begin
        hold_q[i] <= count_rd[i][CW-1:DATA_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (hit[i]) begin
        case (ofs)
          OFS_CTRL: rd_mux = ctrl_rd[i];
          OFS_LO:   rd_mux = count_rd[i][DATA_W-1:0];
          OFS_HI:   rd_mux = hold_q[i];
          default:  rd_mux = '0;
        endcase
      end
    end
    if (addr == SEL_ADDR) rd_mux = {{(DATA_W-NUM_CNT){1'b0}}, sel_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && (addr == SEL_ADDR)) sel_q <= wsel;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign sel   = sel_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/chain_wdog_bank.sv
module chain_wdog_bank
  import cwb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdog_rst_req
);
  localparam int unsigned CW     = 2 * DATA_W;
  localparam int unsigned CTRL_W = PRE_W + SRC_W + 4;

  cnt_cfg_t [NUM_CNT-1:0]         cfg_v;
  logic [NUM_CNT-1:0]             active_v;
  logic [NUM_CNT-1:0]             endc_v;
  logic [NUM_CNT-1:0]             en_v;
  logic [NUM_CNT-1:0]             trig_v;
  logic [NUM_CNT-1:0][CW-1:0]     count_v;
  logic [NUM_CNT-1:0][DATA_W-1:0] ctrl_rd;
  logic [NUM_CNT-1:0]             ctrl_we;
  logic [NUM_CNT-1:0]             lo_we;
  logic [NUM_CNT-1:0]             hi_we;
  logic [NUM_CNT-1:0]             sel_v;
  logic                           rst_req_q;

  cwb_regif #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wsel     (wdata[NUM_CNT-1:0]),
    .ctrl_rd  (ctrl_rd),
    .count_rd (count_v),
    .ctrl_we  (ctrl_we),
    .lo_we    (lo_we),
    .hi_we    (hi_we),
    .sel      (sel_v),
    .rdata    (rdata)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i == 0) begin : g_first
      assign trig_v[i] = 1'b0;
    end else begin : g_chain
      assign trig_v[i] = endc_v[i-1];
    end

    cwb_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we[i]),
      .lo_we    (lo_we[i]),
      .hi_we    (hi_we[i]),
      .wdata    (wdata),
      .trig_in  (trig_v[i]),
      .cfg_o    (cfg_v[i]),
      .active_o (active_v[i]),
      .count_o  (count_v[i]),
      .endc_o   (endc_v[i])
    );

    assign en_v[i]    = cfg_v[i].en;
    assign ctrl_rd[i] = {{(DATA_W-CTRL_W){1'b0}}, cfg_v[i].pre, cfg_v[i].src,
                         cfg_v[i].mode, active_v[i], cfg_v[i].en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= |(endc_v & sel_v);
  end

  assign wdog_rst_req = rst_req_q;
endmodule

// File: rtl/cwb_chk.sv
module cwb_chk #(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CW      = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CNT-1:0]         endc,
  input logic [NUM_CNT-1:0]         active,
  input logic [NUM_CNT-1:0]         en,
  input logic [NUM_CNT-1:0]         sel,
  input logic [NUM_CNT-1:0][CW-1:0] count,
  input logic                       rst_req
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_c
    // R4
    endc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      endc[i] |=> !endc[i]);
    // R6
    active_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active[i] |-> en[i]);
    // R6
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active[i] |=> ($stable(count[i]) || active[i]));
  end

  // R9
  rst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(endc & sel)) |=> rst_req);
  // R9
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(endc & sel)) |=> !rst_req);
endmodule

bind chain_wdog_bank cwb_chk #(.NUM_CNT(NUM_CNT), .CW(2*DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .endc    (endc_v),
  .active  (active_v),
  .en      (en_v),
  .sel     (sel_v),
  .count   (count_v),
  .rst_req (wdog_rst_req)
);

// File: tb/chain_wdog_bank_test.sv
`timescale 1ns/1ps
module chain_wdog_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdog_rst_req;

  int total = 0;
  int bad = 0;
  int rst_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chain_wdog_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdog_rst_req(wdog_rst_req)
  );

  always @(negedge clk) if (rst_n && wdog_rst_req) rst_seen++;

  function automatic [7:0] a_ctrl(int i); return 8'(i * 16); endfunction
  function automatic [7:0] a_lo(int i);   return 8'(i * 16 + 4); endfunction
  function automatic [7:0] a_hi(int i);   return 8'(i * 16 + 8); endfunction

  function automatic [31:0] cfg(bit en, bit [1:0] mode, bit [3:0] src, bit [7:0] pre);
    return {16'h0, pre, src, mode, 1'b0, en};
  endfunction
  function automatic [31:0] exp_ctrl(logic [31:0] w, bit act);
    return {16'h0, w[15:2], act, w[0]};
  endfunction
  function automatic int eff_pre(int p);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int base;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(a_ctrl(i), d); check(d, 0, "R1 ctrl");
      rd(a_lo(i), d);   check(d, 0, "R1 lo");
      rd(a_hi(i), d);   check(d, 0, "R1 hi/R8 empty hold");
    end
    rd(8'h40, d); check(d, 0, "R1 sel");
    check(32'(wdog_rst_req), 0, "R1 rst_req");

    // R3 fields, read-only active bit, upper bits zero
    wr(a_ctrl(2), 32'hABCD_EFFE);
    rd(a_ctrl(2), d); check(d, 32'h0000_EFFC, "R3 ctrl fields");
    wr(a_ctrl(2), 32'h0);

    // R2 unmapped addresses
    rd(8'h0C, d); check(d, 0, "R2 unmapped 0x0C");
    rd(8'h44, d); check(d, 0, "R2 unmapped 0x44");

    // R9 select width
    wr(8'h40, 32'hFFFF_FFF5);
    rd(8'h40, d); check(d, 32'h5, "R9 sel mask");
    wr(8'h40, 32'h0);

    // R7 reload writes do not touch live count
    wr(a_lo(3), 32'h0000_1234);
    wr(a_hi(3), 32'h0000_0055);
    rd(a_lo(3), d); check(d, 0, "R7 lo live");
    rd(a_hi(3), d); check(d, 0, "R7 hi live");

    // R8 coherent read: reload {1,0}, prescale 2
    wr(a_lo(0), 32'h0);
    wr(a_hi(0), 32'h1);
    wr(a_ctrl(0), cfg(1, 2'b00, 4'h0, 8'd2));
    rd(a_lo(0), d);  check(d, 32'h0, "R8 lo before borrow");
    rd(a_hi(0), d);  check(d, 32'h1, "R8 captured hi");
    rd(a_lo(0), d);  check(d, 32'hFFFF_FFFF, "R8 lo after borrow");
    rd(a_hi(0), d);  check(d, 32'h0, "R8 captured hi after borrow");
    wr(a_ctrl(0), 32'h0);

    // R4 live count under random prescale and delay
    for (int it = 0; it < 5; it++) begin
      int unsigned n, h, p, w;
      n = $urandom_range(32'h4000_0000, 100000);
      h = $urandom();
      p = $urandom_range(9, 2);
      w = $urandom_range(20, 0);
      wr(a_ctrl(2), 32'h0);
      wr(a_lo(2), n);
      wr(a_hi(2), h);
      wr(a_ctrl(2), cfg(1, 2'b00, 4'h0, 8'(p)));
      repeat (w) @(negedge clk);
      rd(a_lo(2), d); check(d, n - w / p, "R4 live count lo");
      rd(a_hi(2), d); check(d, h, "R4/R8 live count hi");
    end

    // R6 disable freezes
    wr(a_ctrl(2), cfg(0, 2'b00, 4'h0, 8'd3));
    rd(a_ctrl(2), d); check(d, exp_ctrl(cfg(0, 2'b00, 4'h0, 8'd3), 0), "R6 active cleared");
    rd(a_lo(2), d);
    repeat (6) @(negedge clk);
    rd(a_lo(2), d2); check(d2, d, "R6 count frozen");

    // R4/R9 expiry timing: directed corners then random
    wr(8'h40, 32'h8);
    for (int it = 0; it < 8; it++) begin
      int unsigned n, p, exp_k, first_k, hits;
      n = (it == 0) ? 0 : (it == 1) ? 3 : $urandom_range(6, 0);
      p = (it == 1) ? 0 : $urandom_range(5, 0);
      exp_k = n * eff_pre(p) + 1;
      wr(a_ctrl(3), 32'h0);
      wr(a_lo(3), n);
      wr(a_hi(3), 32'h0);
      wr(a_ctrl(3), cfg(1, 2'b00, 4'h0, 8'(p)));
      first_k = 0; hits = 0;
      for (int k = 1; k <= int'(exp_k) + 3; k++) begin
        @(negedge clk);
        if (wdog_rst_req) begin
          hits++;
          if (first_k == 0) first_k = k;
        end
      end
      check(first_k, exp_k, "R4/R9 expiry cycle");
      check(hits, 1, "R9 single-cycle request");
      rd(a_ctrl(3), d); check(d, exp_ctrl(cfg(1, 2'b00, 4'h0, 8'(p)), 0), "R4 stopped after end");
    end

    // R9 nothing selected: no request
    wr(8'h40, 32'h0);
    base = rst_seen;
    wr(a_ctrl(3), 32'h0);
    wr(a_lo(3), 32'd2);
    wr(a_ctrl(3), cfg(1, 2'b00, 4'h0, 8'd2));
    repeat (10) @(negedge clk);
    check(rst_seen - base, 0, "R9 sel zero no request");
    wr(a_ctrl(3), 32'h0);

    // R5/R10 chained keep-alive
    wr(a_ctrl(0), 32'h0);
    wr(a_lo(0), 32'h0); wr(a_hi(0), 32'h0);
    wr(a_lo(1), 32'd10); wr(a_hi(1), 32'h0);
    wr(a_lo(2), 32'd1000); wr(a_hi(2), 32'h0);
    wr(a_ctrl(2), cfg(1, 2'b11, 4'h5, 8'd2));
    wr(a_ctrl(1), cfg(1, 2'b11, 4'h5, 8'd2));
    wr(8'h40, 32'h2);
    rd(a_ctrl(1), d); check(d, exp_ctrl(cfg(1, 2'b11, 4'h5, 8'd2), 0), "R5 hw mode waits");
    base = rst_seen;
    wr(a_ctrl(0), cfg(1, 2'b00, 4'h0, 8'd2));
    for (int pg = 0; pg < 5; pg++) begin
      repeat (8) @(negedge clk);
      wr(a_ctrl(0), 32'h0);
      wr(a_ctrl(0), cfg(1, 2'b00, 4'h0, 8'd2));
    end
    check(rst_seen - base, 0, "R10 keep-alive holds off request");
    begin
      int first_k;
      first_k = 0;
      for (int k = 1; k <= 30; k++) begin
        @(negedge clk);
        if (wdog_rst_req && first_k == 0) first_k = k;
        if (k == 2) begin
          check(32'(uut.wdog_rst_req), 0, "R10 quiet after ping");
        end
      end
      check(first_k, 22, "R10 expiry after last keep-alive");
    end
    rd(a_ctrl(1), d); check(d, exp_ctrl(cfg(1, 2'b11, 4'h5, 8'd2), 0), "R9 watchdog stopped");
    rd(a_ctrl(2), d); check(d, exp_ctrl(cfg(1, 2'b11, 4'h5, 8'd2), 1), "R5 neighbour retrigger");
    wr(a_ctrl(3), cfg(1, 2'b11, 4'h4, 8'd2));
    rd(a_ctrl(3), d); check(d, exp_ctrl(cfg(1, 2'b11, 4'h4, 8'd2), 0), "R5 other source idle");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule